// File: doc/BRIEF.md
# Up-Count PWM Pair with Per-Event Action Tables

This block drives two PWM outputs from one shared up-counting timebase. The system clock passes through two cascaded power-of-two dividers, and their combined output forms the counter tick. On each tick the counter steps from zero up to a programmable period value and then wraps back to zero. Four counter events are decoded on every tick: counter at zero, counter at period, counter at compare A, and counter at compare B. Each output has its own small action table. The table picks, for each event, whether the output is left alone, cleared, set or toggled. This lets one output pulse between compare A and compare B, or toggle once per period to give a square wave.

Compare values are double-buffered. A write lands in a shadow register, and the active value that the comparators use changes only when the counter wraps to zero, so a duty-cycle change never produces a runt pulse in mid-period. A separate event-trigger stage counts one selected counter event. It raises a sticky interrupt flag on the Nth occurrence of that event, and a write-one-to-clear input resets the flag. While the timebase enable is low, the counter, the dividers and both outputs stay at zero, so several instances can be released together.

Top module: `uppwm_pair`

## Requirements
- R1: While `tb_en` is high, each tick increments `cnt_o` by one. The tick after `cnt_o` equals `period`, it returns to 0, so one cycle spans `period`+1 ticks.
- R2: The tick rate is the clock rate divided by 2^`div_fast_sel` × 2^`div_slow_sel`. For example, settings 1 and 1 give one counter step every 4 clocks, and 2 and 1 give one every 8.
- R3: `cmpa_we` and `cmpb_we` write `cmp_wdata` into shadow registers. The active compare value takes the shadow value only at the tick where the counter wraps to zero, or continuously while `tb_en` is low.
- R4: Each action table encodes a field as 00 none, 01 clear, 10 set or 11 toggle. The fields sit at bits [1:0] for zero, [3:2] for period, [5:4] for compare A and [7:6] for compare B. The output changes on the clock edge of the tick at which the matching counter value is present, and stays unchanged on ticks with no event.
- R5: When several events that carry a non-none action coincide on one tick, only the highest-priority one acts. The order is compare B, then compare A, then period, then zero.
- R6: A toggle on the zero event alone inverts the output once per cycle, giving a 50% square wave with a half-period of `period`+1 ticks.
- R7: With `irq_en` high, the event selected by `irq_sel` (0 zero, 1 period, 2 compare A, 3 compare B) is counted. `irq_flag` sets on the edge of the `irq_prd`-th occurrence (1 to 3), and an `irq_prd` of 0 never sets it.
- R8: `irq_flag` stays set until `irq_clr` is high for a cycle. While the flag is set, further events neither count nor re-assert it. A clear takes precedence over a same-cycle event and restarts the count from zero.
- R9: While `irq_en` is low, selected events are not counted and `irq_flag` does not set.
- R10: While `tb_en` is low, `cnt_o`, `pwm_a` and `pwm_b` are 0 from the next clock edge and hold there.
- R11: After a synchronous reset (`rst_n` low), `cnt_o`, `pwm_a`, `pwm_b` and `irq_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | Timebase run enable; low holds counter and outputs at zero |
| div_fast_sel | input | SEL_W | First divider stage, ratio 2^value |
| div_slow_sel | input | SEL_W | Second divider stage, ratio 2^value |
| period | input | CNT_W | Terminal count of the counter |
| cmpa_we | input | 1 | Write strobe for the compare A shadow |
| cmpb_we | input | 1 | Write strobe for the compare B shadow |
| cmp_wdata | input | CNT_W | Data for compare shadow writes |
| act_a | input | 8 | Action table for output A |
| act_b | input | 8 | Action table for output B |
| irq_en | input | 1 | Event-trigger enable |
| irq_sel | input | 2 | Event selected for the interrupt |
| irq_prd | input | PRD_W | Number of events per interrupt |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| cnt_o | output | CNT_W | Current counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with CNT_W=16, SEL_W=3 and PRD_W=2. It programs a period of 9 at run time, so that hundreds of counter wraps, shadow reloads and event-prescale rollovers happen within a few thousand clocks. With both divider settings at zero, every clock is a tick, so priority collisions and mid-period compare writes can be seen cycle by cycle. Divider settings of 1/1 and 2/1 bring the cascaded division ratios within reach. The 2-bit prescale width covers the full range, from every event to the third event.

// File: rtl/uppwm_pkg.sv
// Shared types and helpers for the up-count PWM pair.
// Assumes action fields are two bits wide and packed in event priority order.
package uppwm_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    localparam int NUM_EV  = 4;
    localparam int EV_ZERO = 0;
    localparam int EV_PRD  = 1;
    localparam int EV_CMPA = 2;
    localparam int EV_CMPB = 3;
    localparam int TBL_W   = 2 * NUM_EV;

    // Resolve one tick: a higher event index overrides a lower one when its field is not none.
    function automatic logic apply_actions(input logic cur,
                                           input logic [TBL_W-1:0] tbl,
                                           input logic [NUM_EV-1:0] ev);
        logic nxt;
        nxt = cur;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev[i]) begin
                case (act_e'(tbl[2*i +: 2]))
                    ACT_CLR:  nxt = 1'b0;
                    ACT_SET:  nxt = 1'b1;
                    ACT_TGL:  nxt = ~cur;
                    default:  nxt = nxt;
                endcase
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/uppwm_clkdiv.sv
// One power-of-two divider stage of the tick chain.
// Passes every 2^sel-th step_in pulse to step_out; the stage clears while run is low.
// Assumes sel changes only while run is low.
module uppwm_clkdiv #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step_in,
    input  logic [SEL_W-1:0] sel,
    output logic             step_out
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          hit;

    assign lim      = CW'((32'd1 << sel) - 32'd1);
    assign hit      = (cnt >= lim);
    assign step_out = run && step_in && hit;

    // Count incoming steps and wrap at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (step_in) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end

    // R10
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

    // R2
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |=> cnt == '0);

endmodule

// File: rtl/uppwm_timebase.sv
// Up-counting timebase with double-buffered compare registers and event decode.
// Counts ticks from 0 to period, then wraps; shadows load into the active compares at the wrap.
// Assumes tick is a single-cycle qualifier that is only high while run is high.
module uppwm_timebase
    import uppwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [CNT_W-1:0]  period,
    input  logic [1:0]        cmp_we,
    input  logic [CNT_W-1:0]  cmp_wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [NUM_EV-1:0] events
);
    logic [1:0][CNT_W-1:0] cmp_sh;
    logic [1:0][CNT_W-1:0] cmp_act;
    logic                  wrap;

    assign wrap = tick && (cnt >= period);

    // Advance the counter on each tick and wrap after the period value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_cmp
        // Capture software writes in the shadow register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_sh[i] <= '0;
            end else if (cmp_we[i]) begin
                cmp_sh[i] <= cmp_wdata;
            end
        end

        // Copy the shadow into the active compare at wrap or while stopped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_act[i] <= '0;
            end else if (!run || wrap) begin
                cmp_act[i] <= cmp_sh[i];
            end
        end

        // R3
        shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cmp_act[i]) |-> ($past(!run) || $past(wrap)));
    end

    assign events[EV_ZERO] = tick && (cnt == '0);
    assign events[EV_PRD]  = tick && (cnt == period);
    assign events[EV_CMPA] = tick && (cnt == cmp_act[0]);
    assign events[EV_CMPB] = tick && (cnt == cmp_act[1]);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt == period) |=> cnt == '0);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt < period) |=> cnt == $past(cnt) + 1'b1);

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/uppwm_action.sv
// Per-output action qualifier.
// Applies the table action of the highest-priority event with a non-none field on each tick.
// Assumes events are already qualified by the tick.
module uppwm_action
    import uppwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NUM_EV-1:0] events,
    input  logic [TBL_W-1:0]  tbl,
    output logic              pwm
);
    // Update the output from the action table; force low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (!run) begin
            pwm <= 1'b0;
        end else begin
            pwm <= apply_actions(pwm, tbl, events);
        end
    end

    // R4
    act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && events == '0) |=> pwm == $past(pwm));

    // R6
    act_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && events == 4'b0001 && tbl[1:0] == 2'b11) |=> pwm != $past(pwm));

    // R10
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm);

endmodule

// File: rtl/uppwm_evtrig.sv
// Event-trigger stage: counts one selected counter event and raises a sticky flag on the Nth one.
// The count holds at its terminal value while the flag is set; clear wins over a same-cycle event.
module uppwm_evtrig
    import uppwm_pkg::*;
#(
    parameter int PRD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] events,
    input  logic              en,
    input  logic [1:0]        sel,
    input  logic [PRD_W-1:0]  prd,
    input  logic              clr,
    output logic              flag
);
    logic [PRD_W-1:0] ecnt;
    logic [PRD_W-1:0] ecnt_nxt;
    logic             sel_ev;

    assign sel_ev   = events[sel];
    assign ecnt_nxt = PRD_W'(ecnt + 1'b1);

    // Prescale the selected event and manage the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            ecnt <= '0;
        end else if (clr) begin
            flag <= 1'b0;
            ecnt <= '0;
        end else if (!en) begin
            ecnt <= '0;
        end else if (!flag && sel_ev && prd != '0) begin
            ecnt <= ecnt_nxt;
            if (ecnt_nxt == prd) begin
                flag <= 1'b1;
            end
        end
    end

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(sel_ev) && $past(en)));

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag) |=> !flag);

endmodule

// File: rtl/uppwm_pair.sv
// Top of the up-count PWM pair: divider chain, timebase, two action qualifiers, event trigger.
// Assumes divider and period settings are changed only while tb_en is low.
module uppwm_pair
    import uppwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int PRD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic [SEL_W-1:0] div_fast_sel,
    input  logic [SEL_W-1:0] div_slow_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             cmpa_we,
    input  logic             cmpb_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [7:0]       act_a,
    input  logic [7:0]       act_b,
    input  logic             irq_en,
    input  logic [1:0]       irq_sel,
    input  logic [PRD_W-1:0] irq_prd,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             irq_flag
);
    localparam int NDIV = 2;
    localparam int NOUT = 2;

    logic [NDIV:0]                 step;
    logic [NDIV-1:0][SEL_W-1:0]    div_sel;
    logic [NUM_EV-1:0]             events;
    logic [NOUT-1:0][TBL_W-1:0]    tbls;
    logic [NOUT-1:0]               pwm;

    assign step[0]    = tb_en;
    assign div_sel[0] = div_fast_sel;
    assign div_sel[1] = div_slow_sel;
    assign tbls[0]    = act_a;
    assign tbls[1]    = act_b;
    assign pwm_a      = pwm[0];
    assign pwm_b      = pwm[1];

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        uppwm_clkdiv #(.SEL_W(SEL_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (tb_en),
            .step_in  (step[d]),
            .sel      (div_sel[d]),
            .step_out (step[d+1])
        );
    end

    uppwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tb_en),
        .tick      (step[NDIV]),
        .period    (period),
        .cmp_we    ({cmpb_we, cmpa_we}),
        .cmp_wdata (cmp_wdata),
        .cnt       (cnt_o),
        .events    (events)
    );

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        uppwm_action u_act (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (tb_en),
            .events (events),
            .tbl    (tbls[o]),
            .pwm    (pwm[o])
        );
    end

    uppwm_evtrig #(.PRD_W(PRD_W)) u_et (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .en     (irq_en),
        .sel    (irq_sel),
        .prd    (irq_prd),
        .clr    (irq_clr),
        .flag   (irq_flag)
    );

endmodule

// File: tb/sim_uppwm_pair.sv
`timescale 1ns/1ps
module sim_uppwm_pair;
    localparam int CNT_W = 16;
    localparam int SEL_W = 3;
    localparam int PRD_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tb_en = 1'b0;
    logic [SEL_W-1:0] div_fast_sel = '0;
    logic [SEL_W-1:0] div_slow_sel = '0;
    logic [CNT_W-1:0] period = '0;
    logic             cmpa_we = 1'b0;
    logic             cmpb_we = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic [7:0]       act_a = '0;
    logic [7:0]       act_b = '0;
    logic             irq_en = 1'b0;
    logic [1:0]       irq_sel = '0;
    logic [PRD_W-1:0] irq_prd = '0;
    logic             irq_clr = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic             pwm_a, pwm_b, irq_flag;

    int    checks = 0;
    int    errors = 0;
    string req_tag = "R11";

    always #4 clk = ~clk;

    uppwm_pair #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PRD_W(PRD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
        .div_fast_sel(div_fast_sel), .div_slow_sel(div_slow_sel),
        .period(period), .cmpa_we(cmpa_we), .cmpb_we(cmpb_we),
        .cmp_wdata(cmp_wdata), .act_a(act_a), .act_b(act_b),
        .irq_en(irq_en), .irq_sel(irq_sel), .irq_prd(irq_prd), .irq_clr(irq_clr),
        .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq_flag(irq_flag)
    );

    typedef struct packed {
        logic [CNT_W-1:0] c;
        logic             a;
        logic             b;
        logic             f;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference resolution: scan from the highest-priority event down.
    function automatic logic ref_resolve(input logic cur, input logic [7:0] t, input logic [3:0] ev);
        for (int i = 3; i >= 0; i--) begin
            if (ev[i] && t[2*i +: 2] != 2'b00) begin
                case (t[2*i +: 2])
                    2'b01:   return 1'b0;
                    2'b10:   return 1'b1;
                    default: return ~cur;
                endcase
            end
        end
        return cur;
    endfunction

    // Reference model state.
    int               m_d1, m_d2, m_ecnt;
    logic [CNT_W-1:0] m_c, m_ca, m_cb, m_sa, m_sb;
    logic             m_a, m_b, m_f;

    // Driver side of the scoreboard: predict each cycle and queue the expectation.
    always @(posedge clk) begin
        int l1, l2;
        logic t1, tk, wr, sev;
        logic [3:0] ev;
        exp_t e;
        if (!rst_n) begin
            m_d1 = 0; m_d2 = 0; m_ecnt = 0;
            m_c = '0; m_ca = '0; m_cb = '0; m_sa = '0; m_sb = '0;
            m_a = 1'b0; m_b = 1'b0; m_f = 1'b0;
        end else begin
            l1 = (1 << div_fast_sel) - 1;
            l2 = (1 << div_slow_sel) - 1;
            t1 = tb_en && (m_d1 >= l1);
            tk = t1 && (m_d2 >= l2);
            ev = {tk && m_c == m_cb, tk && m_c == m_ca, tk && m_c == period, tk && m_c == 0};
            wr = tk && (m_c >= period);
            if (!tb_en) begin
                m_a = 1'b0; m_b = 1'b0;
            end else begin
                m_a = ref_resolve(m_a, act_a, ev);
                m_b = ref_resolve(m_b, act_b, ev);
            end
            sev = ev[irq_sel];
            if (irq_clr) begin
                m_f = 1'b0; m_ecnt = 0;
            end else if (!irq_en) begin
                m_ecnt = 0;
            end else if (!m_f && sev && irq_prd != 0) begin
                m_ecnt = m_ecnt + 1;
                if (m_ecnt == int'(irq_prd)) m_f = 1'b1;
            end
            if (!tb_en || wr) begin
                m_ca = m_sa; m_cb = m_sb;
            end
            if (cmpa_we) m_sa = cmp_wdata;
            if (cmpb_we) m_sb = cmp_wdata;
            if (!tb_en) m_c = '0;
            else if (tk) m_c = wr ? '0 : m_c + 1'b1;
            if (!tb_en) begin
                m_d1 = 0; m_d2 = 0;
            end else begin
                if (t1) m_d2 = (m_d2 >= l2) ? 0 : m_d2 + 1;
                m_d1 = (m_d1 >= l1) ? 0 : m_d1 + 1;
            end
        end
        e.c = m_c; e.a = m_a; e.b = m_b; e.f = m_f;
        exp_q.push_back(e);
    end

    // Monitor side of the scoreboard: compare away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(req_tag, "cnt_o", int'(cnt_o), int'(e.c));
            chk(req_tag, "pwm_a", int'(pwm_a), int'(e.a));
            chk(req_tag, "pwm_b", int'(pwm_b), int'(e.b));
            chk(req_tag, "irq_flag", int'(irq_flag), int'(e.f));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (int'(cnt_o) == v) return;
        end
    endtask

    task automatic write_cmp(input logic wa, input logic wb, input int v);
        @(negedge clk);
        cmp_wdata = CNT_W'(v); cmpa_we = wa; cmpb_we = wb;
        @(negedge clk);
        cmpa_we = 1'b0; cmpb_we = 1'b0;
    endtask

    // Clocks between two changes of the counter value.
    task automatic measure_step(output int n);
        logic [CNT_W-1:0] cur;
        cur = cnt_o;
        for (int i = 0; i < 100 && cnt_o == cur; i++) @(negedge clk);
        cur = cnt_o; n = 0;
        for (int i = 0; i < 100 && cnt_o == cur; i++) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        int n, mx;
        logic prev;
        // R11: reset state
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "cnt_o reset", int'(cnt_o), 0);
        chk("R11", "pwm_a reset", int'(pwm_a), 0);
        chk("R11", "irq_flag reset", int'(irq_flag), 0);

        // R1 / R4: set on zero, clear on own compare
        req_tag = "R4";
        period = 16'd9;
        act_a = 8'h12;
        act_b = 8'h42;
        write_cmp(1'b1, 1'b0, 3);
        write_cmp(1'b0, 1'b1, 6);
        @(negedge clk); tb_en = 1'b1;
        mx = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
        end
        chk("R1", "max count", mx, 9);

        // R3: mid-period write only lands at the wrap
        req_tag = "R3";
        wait_cnt(2);
        write_cmp(1'b1, 1'b0, 6);
        wait_cnt(5);
        chk("R3", "pwm_a before reload", int'(pwm_a), 0);
        wait_cnt(5);
        chk("R3", "pwm_a after reload", int'(pwm_a), 1);
        cycles(10);

        // R5: coincident compare events
        req_tag = "R5";
        write_cmp(1'b1, 1'b1, 4);
        act_a = 8'h62;
        cycles(25);
        wait_cnt(6);
        chk("R5", "cmpB clear beats cmpA set", int'(pwm_a), 0);
        act_a = 8'h92;
        cycles(12);
        wait_cnt(6);
        chk("R5", "cmpB set beats cmpA clear", int'(pwm_a), 1);

        // R6: toggle on zero
        req_tag = "R6";
        act_b = 8'h03;
        cycles(12);
        prev = pwm_b;
        for (int i = 0; i < 100 && pwm_b == prev; i++) @(negedge clk);
        prev = pwm_b; n = 0;
        for (int i = 0; i < 100 && pwm_b == prev; i++) begin
            @(negedge clk); n++;
        end
        chk("R6", "toggle half-period", n, 10);

        // R7: flag on third zero event
        req_tag = "R7";
        wait_cnt(5);
        irq_sel = 2'd0; irq_prd = 2'd3; irq_en = 1'b1;
        wait_cnt(1);
        chk("R7", "flag after 1st zero", int'(irq_flag), 0);
        wait_cnt(1);
        chk("R7", "flag after 2nd zero", int'(irq_flag), 0);
        wait_cnt(1);
        chk("R7", "flag after 3rd zero", int'(irq_flag), 1);

        // R8: sticky, then clear and restart
        req_tag = "R8";
        cycles(25);
        chk("R8", "flag sticky", int'(irq_flag), 1);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R8", "flag cleared", int'(irq_flag), 0);
        irq_sel = 2'd2; irq_prd = 2'd1;
        cycles(30);
        irq_prd = 2'd0;
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        cycles(30);
        chk("R7", "prescale zero never fires", int'(irq_flag), 0);

        // R9: disabled trigger
        req_tag = "R9";
        irq_prd = 2'd1; irq_en = 1'b0;
        cycles(30);
        chk("R9", "flag while disabled", int'(irq_flag), 0);

        // R2: cascaded division
        req_tag = "R2";
        @(negedge clk); tb_en = 1'b0;
        div_fast_sel = 3'd1; div_slow_sel = 3'd1;
        @(negedge clk); tb_en = 1'b1;
        measure_step(n);
        chk("R2", "step for 1/1", n, 4);
        cycles(60);
        @(negedge clk); tb_en = 1'b0;
        div_fast_sel = 3'd2; div_slow_sel = 3'd1;
        @(negedge clk); tb_en = 1'b1;
        measure_step(n);
        chk("R2", "step for 2/1", n, 8);
        cycles(100);

        // R10: hold while stopped
        req_tag = "R10";
        act_a = 8'h02;
        wait_cnt(3);
        tb_en = 1'b0;
        cycles(2);
        chk("R10", "cnt_o held", int'(cnt_o), 0);
        chk("R10", "pwm_a held", int'(pwm_a), 0);
        chk("R10", "pwm_b held", int'(pwm_b), 0);
        cycles(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1: watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule